// File: doc/BRIEF.md
# Open-Drain Single-Wire Serial Transmitter

This block turns bytes into asynchronous serial frames on a shared wire that has an external pull-up and is never actively driven high. The block does not drive a level. It controls the output-enable of a pull-low driver whose data value is fixed at 0. Enabling the driver puts a 0 on the wire. Releasing it lets the pull-up return the wire to 1. Each frame is a start bit, eight data bits with the least significant bit first, and an idle gap that acts as the stop bit.

All timing comes from a tick enable that an upstream divider produces at eight times the baud rate, nominally 115200 baud. Every bit lasts exactly eight ticks. A four-entry queue with a valid/ready handshake feeds the serialiser. After the queue runs empty, the block keeps `busy` high for a guard time of eleven bit periods, counted from the tick that started the last frame. It then pulses `tx_done`, so that a turnaround controller can hand the wire to a receiver.

Top module: `owire_tx`

## Requirements
- R1: The driver enable changes only on a clock edge where `tick_en` is high. The start bit and each data bit last exactly 8 ticks.
- R2: A frame enables the driver for the start bit, then sends data bits 0 through 7 in that order. A data bit of 0 enables the driver (`line_oe`=1) and a data bit of 1 releases it (`line_oe`=0).
- R3: `line_out` is always 0. `line_oe` is 0 after reset and whenever no frame is in progress.
- R4: Before every start bit the driver has been released for at least 8 ticks. When bytes are already queued, consecutive start bits are exactly 80 ticks apart.
- R5: The queue holds 4 bytes. `in_ready` is low exactly while 4 bytes are held. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. Bytes leave in the order they were accepted.
- R6: `tx_done` is a one-cycle pulse on the tick edge 88 ticks after the tick that started the last queued frame. Accepting a new byte first restarts the guard. `busy` is high from an accepted byte until that pulse, and low after reset.
- R7: A synchronous active-low reset empties the queue and releases the wire. Bytes held before the reset are never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Oversample enable, 8 per bit period |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Queue has room |
| line_oe | output | 1 | Pull-low driver enable (1 = wire low) |
| line_out | output | 1 | Driver data value, fixed at 0 |
| busy | output | 1 | Transfer or guard time in progress |
| tx_done | output | 1 | One-cycle pulse when the guard time expires |

## Verification
Every result of this block moves on a tick edge. `line_oe` changes on the tick edge that a state change takes effect, and `tx_done` rises on the tick edge that completes the 88th tick after the last start. `in_ready` follows an accepted byte one clock later. The bench produces the ticks itself and counts them in the same negative-edge process that samples the outputs. It therefore compares each frame against the scoreboard's expected byte at every tick offset, from 0 to 72 ticks after the start edge, and checks `tx_done` only at an exact tick distance from the last start. A pause of the ticks in the middle of a frame confirms that the wire holds its state between tick edges.

// File: rtl/owire_tx_pkg.sv
package owire_tx_pkg;

  typedef enum logic [1:0] {
    ST_GAP   = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2
  } tx_state_e;

  // Guard period in ticks: bit periods times oversample ratio.
  function automatic int unsigned guard_ticks(input int unsigned osr,
                                              input int unsigned bits);
    return osr * bits;
  endfunction

  // Open-drain mapping: a 0 bit enables the pull-low driver.
  function automatic logic pull_for_bit(input logic b);
    return ~b;
  endfunction

  // Saturating step used for the idle-gap counter.
  function automatic int unsigned sat_inc(input int unsigned v,
                                          input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/owire_tx_fifo.sv
module owire_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R5
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R5
  AST_FULL_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full); // R5

endmodule

// File: rtl/owire_tx_ser.sv
module owire_tx_ser
  import owire_tx_pkg::*;
#(
  parameter int W   = 8,
  parameter int OSR = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         have_byte,
  input  logic [W-1:0] byte_in,
  output logic         pop,
  output logic         line_oe
);
  localparam int PW = $clog2(OSR);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam int GW = $clog2(OSR + 1);

  tx_state_e     state;
  logic [PW-1:0] phase;
  logic [BW-1:0] bit_idx;
  logic [W-1:0]  shreg;
  logic [GW-1:0] gap_cnt;
  logic          gap_ok, last_phase, last_bit;

  assign gap_ok     = (gap_cnt == GW'(OSR));
  assign last_phase = (phase == PW'(OSR - 1));
  assign last_bit   = (bit_idx == BW'(W - 1));
  assign pop        = tick && (state == ST_GAP) && gap_ok && have_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_GAP;
      phase   <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      gap_cnt <= '0;
      line_oe <= 1'b0;
    end else if (tick) begin
      case (state)
        ST_GAP: begin
          if (pop) begin
            state   <= ST_START;
            phase   <= '0;
            shreg   <= byte_in;
            line_oe <= 1'b1;
          end else begin
            gap_cnt <= GW'(sat_inc(int'(gap_cnt), OSR));
          end
        end
        ST_START: begin
          if (last_phase) begin
            phase   <= '0;
            bit_idx <= '0;
            state   <= ST_DATA;
            line_oe <= pull_for_bit(shreg[0]);
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_DATA: begin
          if (last_phase) begin
            phase <= '0;
            if (last_bit) begin
              state   <= ST_GAP;
              line_oe <= 1'b0;
              gap_cnt <= GW'(1);
            end else begin
              bit_idx <= bit_idx + 1'b1;
              shreg   <= shreg >> 1;
              line_oe <= pull_for_bit(shreg[1]);
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: state <= ST_GAP;
      endcase
    end
  end

  AST_OE_HOLDS_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(line_oe)); // R1
  AST_START_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> line_oe); // R2
  AST_RELEASED_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !line_oe); // R4
  AST_GAP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> !line_oe); // R3

endmodule

// File: rtl/owire_tx_guard.sv
module owire_tx_guard #(
  parameter int GUARD_TICKS = 88
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic accept,
  input  logic q_empty,
  output logic busy,
  output logic done_pulse
);
  localparam int CW = $clog2(GUARD_TICKS + 1);

  logic [CW-1:0] cnt;
  logic          idle_r;
  logic          expire;

  assign expire = !idle_r && q_empty && tick && (cnt == CW'(GUARD_TICKS - 1));
  assign busy   = !idle_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      idle_r     <= 1'b1;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (accept) begin
        cnt    <= '0;
        idle_r <= 1'b0;
      end else if (!q_empty) begin
        cnt <= '0;
      end else if (expire) begin
        cnt        <= '0;
        idle_r     <= 1'b1;
        done_pulse <= 1'b1;
      end else if (!idle_r && tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R6
  AST_DONE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (q_empty && !busy)); // R6
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R6

endmodule

// File: rtl/owire_tx.sv
module owire_tx
  import owire_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int OSR        = 8,
  parameter int GUARD_BITS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              line_oe,
  output logic              line_out,
  output logic              busy,
  output logic              tx_done
);
  localparam int GUARD_TICKS = int'(guard_ticks(OSR, GUARD_BITS));

  logic              q_full, q_empty, accept, frame_pop;
  logic [DATA_W-1:0] q_head;

  assign in_ready = !q_full;
  assign accept   = in_valid && in_ready;
  assign line_out = 1'b0;

  owire_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_data (in_data),
    .pop       (frame_pop),
    .head      (q_head),
    .empty     (q_empty),
    .full      (q_full)
  );

  owire_tx_ser #(.W(DATA_W), .OSR(OSR)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_en),
    .have_byte (!q_empty),
    .byte_in   (q_head),
    .pop       (frame_pop),
    .line_oe   (line_oe)
  );

  owire_tx_guard #(.GUARD_TICKS(GUARD_TICKS)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_en),
    .accept     (accept),
    .q_empty    (q_empty),
    .busy       (busy),
    .done_pulse (tx_done)
  );

  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $past(tick_en)); // R6
  AST_READY_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pop && !accept) |=> in_ready); // R5

endmodule

// File: tb/owire_tx_bench.sv
module owire_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int OSR        = 8;
  localparam int FRAME      = 10 * OSR;
  localparam int DRIVEN     = 9 * OSR;
  localparam int GUARD      = 11 * OSR;

  logic       clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, line_oe, line_out, busy, tx_done;

  int n_checks = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  int starts[$];
  int tick_no = 0, div_cnt = 0;
  bit tick_hold = 0;
  bit in_frame = 0;
  int start_tick = 0, release_tick = 0, last_start = -100000, shape_err = 0, d = 0;
  logic [7:0] got = '0, want = '0;
  logic exp_oe;
  bit reported = 0;

  owire_tx u_owire_tx (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .line_oe(line_oe),
    .line_out(line_out), .busy(busy), .tx_done(tx_done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    end
  endtask

  // Monitor and tick source share one process so ordering is fixed.
  always @(negedge clk) begin
    if (!rst_n) begin
      in_frame     = 0;
      release_tick = tick_no;
    end else if (tick_en) begin
      tick_no++;
      if (!in_frame) begin
        if (tx_done)
          check((tick_no - last_start == GUARD) && !busy, "R6",
                "tx_done tick offset from last start", tick_no - last_start, GUARD);
        if (line_oe) begin
          in_frame   = 1;
          start_tick = tick_no;
          shape_err  = 0;
          got        = '0;
          check(tick_no - release_tick >= OSR, "R4", "released ticks before start",
                tick_no - release_tick, OSR);
          check(busy, "R6", "busy during frame", int'(busy), 1);
          if (exp_q.size() == 0) begin
            check(0, "R7", "frame with no byte expected", 1, 0);
            want = '0;
          end else begin
            want = exp_q[0];
          end
          starts.push_back(tick_no);
        end
      end else begin
        d = tick_no - start_tick;
        if (tx_done) check(0, "R6", "tx_done inside a frame", 1, 0);
        if (d < DRIVEN) begin
          exp_oe = (d < OSR) ? 1'b1 : ~want[(d - OSR) / OSR];
          if (line_oe !== exp_oe) shape_err++;
          if (d >= OSR && (d % OSR) == OSR / 2) got[(d - OSR) / OSR] = ~line_oe;
        end else begin
          check((line_oe == 1'b0) && (shape_err == 0), "R1",
                "ticks off the expected start/data bit pattern", shape_err, 0);
          if (exp_q.size() > 0) begin
            check(got == exp_q[0], "R2", "byte read from wire", got, exp_q[0]);
            void'(exp_q.pop_front());
          end
          in_frame     = 0;
          release_tick = tick_no;
          last_start   = start_tick;
        end
      end
    end else if (tx_done) begin
      check(0, "R6", "tx_done off a tick edge", 1, 0);
    end
    div_cnt = (div_cnt + 1) % TICK_DIV;
    tick_en = (div_cnt == 0) && !tick_hold;
  end

  task automatic push(input logic [7:0] b, input bit track);
    @(negedge clk);
    in_data  = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    if (track) exp_q.push_back(b);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!tx_done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    check(tx_done, req, "tx_done seen", int'(tx_done), 1);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "WD", "watchdog expired", 1, 0);
    report();
    $finish;
  end

  initial begin
    logic held;
    // Reset state
    do_reset();
    @(negedge clk);
    check(in_ready == 1'b1, "R5", "in_ready after reset", int'(in_ready), 1);
    check(line_oe == 1'b0, "R3", "line_oe after reset", int'(line_oe), 0);
    check(line_out == 1'b0, "R3", "line_out value", int'(line_out), 0);
    check(busy == 1'b0 && tx_done == 1'b0, "R6", "busy/tx_done after reset",
          int'(busy), 0);

    // Fill the queue before the first gap completes, then back-to-back frames
    starts.delete();
    push(8'h01, 1); push(8'h80, 1); push(8'hFF, 1); push(8'h00, 1);
    check(in_ready == 1'b0, "R5", "in_ready with 4 queued", int'(in_ready), 0);
    push(8'h5A, 1);
    wait_done("R6");
    check(starts.size() == 5, "R5", "frames sent in burst", starts.size(), 5);
    for (int i = 1; i < starts.size(); i++)
      check(starts[i] - starts[i-1] == FRAME, "R4", "start spacing back-to-back",
            starts[i] - starts[i-1], FRAME);
    check(busy == 1'b0 && line_oe == 1'b0, "R3", "idle after done", int'(line_oe), 0);

    // Single bytes with idle between
    push(8'hA5, 1);
    wait_done("R6");
    push(8'h3C, 1);
    wait_done("R6");

    // New byte during the guard window restarts it
    push(8'hC6, 1);
    repeat (TICK_DIV * (DRIVEN + 4)) @(negedge clk);
    check(busy == 1'b1, "R6", "busy inside guard", int'(busy), 1);
    push(8'h69, 1);
    wait_done("R6");

    // Tick pause mid-frame holds the wire
    push(8'h96, 1);
    while (!line_oe) @(negedge clk);
    repeat (TICK_DIV * 20) @(negedge clk);
    tick_hold = 1;
    @(negedge clk);
    @(negedge clk);
    held = line_oe;
    begin
      int changed;
      changed = 0;
      repeat (60) begin
        @(negedge clk);
        if (line_oe !== held) changed++;
      end
      check(changed == 0, "R1", "line_oe changes without ticks", changed, 0);
    end
    tick_hold = 0;
    wait_done("R6");

    // Reset discards queued bytes
    do_reset();
    push(8'h11, 0); push(8'h22, 0);
    do_reset();
    @(negedge clk);
    check(in_ready == 1'b1 && busy == 1'b0, "R7", "queue empty after reset",
          int'(busy), 0);
    check(line_oe == 1'b0, "R7", "wire released after reset", int'(line_oe), 0);
    starts.delete();
    repeat (TICK_DIV * 200) @(negedge clk);
    check(starts.size() == 0, "R7", "frames after reset", starts.size(), 0);
    push(8'hE7, 1);
    wait_done("R6");

    check(exp_q.size() == 0, "R2", "expected bytes left unsent", exp_q.size(), 0);
    report();
    $finish;
  end

endmodule